// File: doc/BRIEF.md
# Double-to-Single Store Narrowing Converter

This block turns a 64-bit double-precision bit pattern into the 32-bit single-precision pattern that a floating-point store writes to memory. It is purely combinational and does no arithmetic. It does not round and it raises no flags.

Values whose exponent fits the single-precision normal range are narrowed by picking bits. Infinities and NaNs take the same route. Values just below that range become single-precision denormals: the significand, with its hidden one restored, is shifted right by an amount set by the exponent. Anything smaller collapses to a zero that keeps the input's sign. Low-order bits that fall off the end are simply discarded.

Top module: `dp_store_narrow`

## Requirements
- R1: When the biased exponent in input bits 62:52 is greater than 896, output bits 31:30 equal input bits 63:62 and output bits 29:0 equal input bits 58:29.
- R2: Infinities (exponent 2047, zero fraction) and NaNs (exponent 2047, nonzero fraction) follow the R1 path. For example, 0x7FF0000000000000 gives 0x7F800000, and a NaN keeps the top 23 fraction bits as its payload.
- R3: When the exponent is 896 or less, output bit 31 equals input bit 63.
- R4: When the exponent is between 874 and 896 inclusive, output bits 30:23 are zero. Output bits 22:0 are the 53-bit value {1, input bits 51:0} shifted right by (926 − exponent).
- R5: When the exponent is below 874, the output is {input bit 63, 31 zeros}. Both signed zeros therefore map to the zero of the same sign.
- R6: Bits shifted or dropped out of the result are discarded without rounding. This applies on both the R1 path and the R4 path.
- R7: The path switch sits exactly at the range edges. Exponent 897 with a zero fraction gives 0x00800000, and exponent 896 gives 0x00400000. Exponent 874 gives 0x00000001, and exponent 873 gives 0x00000000 (the sign bit is kept in each case).
- R8: The output depends only on the present input value and is valid in the same cycle, with no state held between inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dbl_in | input | 64 | Double-precision bit pattern to narrow |
| sgl_out | output | 32 | Single-precision bit pattern produced |

## Verification
On the denormal route, sign pass-through and the exponent-driven significand shift both act on the same output word in the same cycle. One slip, such as a lost sign or a shift off by one, corrupts only part of that word.

The bench provokes this with negative inputs at the edges, exponents 896 and 874, as well as at random exponents across 874 to 896. It judges the full 32-bit word against an independent halving-loop reference, so that bit 31 and bits 22:0 are checked together.

Adjacent vectors that straddle 897/896 and 874/873 are applied back to back. This shows that the route selection changes on exactly one exponent step.

// File: rtl/dp_sn_pkg.sv
package dp_sn_pkg;

    localparam int DBL_W      = 64;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int SGL_W      = 32;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int DBL_BIAS   = 1023;
    localparam int SGL_BIAS   = 127;

    // Highest double exponent that is NOT a single normal (896).
    localparam int NORM_FLOOR   = DBL_BIAS - SGL_BIAS;
    // Lowest double exponent that still yields a nonzero single denormal (874).
    localparam int DENORM_FLOOR = NORM_FLOOR - SGL_FRAC_W + 1;
    localparam int SIG_W        = DBL_FRAC_W + 1;
    // Shift amount = SHIFT_BASE - exponent (926).
    localparam int SHIFT_BASE   = NORM_FLOOR + (DBL_FRAC_W - SGL_FRAC_W) + 1;
    localparam int SHAMT_W      = $clog2(SIG_W);
    // Single exponent keeps the top bit and the low bits of the double exponent.
    localparam int EXP_LOW_W    = SGL_EXP_W - 1;
    localparam int FRAC_DROP    = DBL_FRAC_W - SGL_FRAC_W;

    typedef struct packed {
        logic                  sign;
        logic [DBL_EXP_W-1:0]  exp;
        logic [DBL_FRAC_W-1:0] frac;
    } dbl_t;

    typedef struct packed {
        logic                  sign;
        logic [SGL_EXP_W-1:0]  exp;
        logic [SGL_FRAC_W-1:0] frac;
    } sgl_t;

    typedef enum logic [1:0] {
        RANGE_NORMAL = 2'd0,
        RANGE_DENORM = 2'd1,
        RANGE_FLUSH  = 2'd2
    } range_e;

    function automatic range_e range_of(input logic [DBL_EXP_W-1:0] e);
        if (int'(e) > NORM_FLOOR)
            return RANGE_NORMAL;
        else if (int'(e) >= DENORM_FLOOR)
            return RANGE_DENORM;
        else
            return RANGE_FLUSH;
    endfunction

endpackage

// File: rtl/dp_sn_classify.sv
module dp_sn_classify
    import dp_sn_pkg::*;
#(
    parameter int EXP_W = DBL_EXP_W
) (
    input  logic [EXP_W-1:0] exp_in,
    output range_e           range_out
);
    always_comb begin
        range_out = range_of(exp_in);
    end
endmodule

// File: rtl/dp_sn_bitsel.sv
module dp_sn_bitsel
    import dp_sn_pkg::*;
#(
    parameter int LOW_W  = EXP_LOW_W,
    parameter int FRAC_W = SGL_FRAC_W
) (
    input  logic              sign_in,
    input  logic              exp_top_in,
    input  logic [LOW_W-1:0]  exp_low_in,
    input  logic [FRAC_W-1:0] frac_hi_in,
    output sgl_t              sgl_out
);
    // Pure bit selection: the rebias happens implicitly because the
    // double exponent bits 9:7 equal the inverse of bit 10 in range.
    always_comb begin
        sgl_out.sign = sign_in;
        sgl_out.exp  = {exp_top_in, exp_low_in};
        sgl_out.frac = frac_hi_in;
    end
endmodule

// File: rtl/dp_sn_denorm.sv
module dp_sn_denorm
    import dp_sn_pkg::*;
#(
    parameter int EXP_W  = DBL_EXP_W,
    parameter int FRAC_W = DBL_FRAC_W,
    parameter int OUT_W  = SGL_FRAC_W
) (
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic              enable,
    output logic [OUT_W-1:0]  frac_out
);
    localparam int SW   = FRAC_W + 1;
    localparam int AW   = $clog2(SW);

    logic [AW-1:0] shamt;
    logic [SW-1:0] stage [0:AW];

    always_comb begin
        shamt = AW'(SHIFT_BASE - int'(exp_in));
    end

    assign stage[0] = {1'b1, frac_in};

    // Logarithmic right shifter: one stage per shift-amount bit.
    generate
        for (genvar k = 0; k < AW; k++) begin : g_stage
            assign stage[k+1] = shamt[k] ? (stage[k] >> (1 << k)) : stage[k];
        end
    endgenerate

    // Only the low OUT_W bits may receive significand bits.
    always_comb begin
        frac_out = enable ? OUT_W'(stage[AW]) : '0;
    end
endmodule

// File: rtl/dp_store_narrow.sv
module dp_store_narrow
    import dp_sn_pkg::*;
(
    input  logic [63:0] dbl_in,
    output logic [31:0] sgl_out
);
    dbl_t   d;
    range_e rng;
    sgl_t   norm_res;
    sgl_t   res;
    logic [SGL_FRAC_W-1:0] den_frac;

    assign d = dbl_t'(dbl_in);

    dp_sn_classify #(.EXP_W(DBL_EXP_W)) u_classify (
        .exp_in    (d.exp),
        .range_out (rng)
    );

    dp_sn_bitsel #(.LOW_W(EXP_LOW_W), .FRAC_W(SGL_FRAC_W)) u_bitsel (
        .sign_in    (d.sign),
        .exp_top_in (d.exp[DBL_EXP_W-1]),
        .exp_low_in (d.exp[EXP_LOW_W-1:0]),
        .frac_hi_in (d.frac[DBL_FRAC_W-1 -: SGL_FRAC_W]),
        .sgl_out    (norm_res)
    );

    dp_sn_denorm #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W), .OUT_W(SGL_FRAC_W)) u_denorm (
        .exp_in   (d.exp),
        .frac_in  (d.frac),
        .enable   (rng == RANGE_DENORM),
        .frac_out (den_frac)
    );

    always_comb begin
        res = '0;
        unique case (rng)
            RANGE_NORMAL: res = norm_res;
            RANGE_DENORM: begin
                res.sign = d.sign;
                res.frac = den_frac;
            end
            default: res.sign = d.sign;
        endcase
    end

    assign sgl_out = SGL_W'(res);
endmodule

// File: rtl/dp_store_narrow_chk.sv
module dp_store_narrow_chk (
    input logic [63:0] dbl_in,
    input logic [31:0] sgl_out
);
    logic [10:0] e;
    assign e = dbl_in[62:52];

    always_comb begin
        if (!$isunknown(dbl_in)) begin
            // R3 (and R1 bit 31): sign always survives
            p_sign_kept_r3: assert (sgl_out[31] == dbl_in[63])
                else $error("sign lost");
            if (e > 11'd896) begin
                p_bitsel_r1: assert (sgl_out[29:0] == dbl_in[58:29])
                    else $error("bit selection wrong");
            end
            if (e <= 11'd896) begin
                p_exp_zero_r4: assert (sgl_out[30:23] == 8'd0)
                    else $error("denormal exponent not zero");
            end
            if (e <= 11'd896 && e >= 11'd874) begin
                p_lead_one_r7: assert (sgl_out[22:0] != 23'd0)
                    else $error("denormal lost leading one");
            end
            if (e < 11'd874) begin
                p_flush_r5: assert (sgl_out[30:0] == 31'd0)
                    else $error("flush not zero");
            end
        end
    end
endmodule

bind dp_store_narrow dp_store_narrow_chk chk_i (
    .dbl_in  (dbl_in),
    .sgl_out (sgl_out)
);

// File: tb/dp_store_narrow_tb_top.sv
module dp_store_narrow_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] dbl_in = 64'd0;
    logic [31:0] sgl_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] q_exp [$];
    logic [63:0] q_in  [$];
    string       q_tag [$];

    always #2 clk = ~clk;

    dp_store_narrow dut_i (
        .dbl_in  (dbl_in),
        .sgl_out (sgl_out)
    );

    // Independent reference: halving loop for the denormal route.
    function automatic logic [31:0] ref_narrow(input logic [63:0] v);
        int unsigned ex = v[62:52];
        logic [52:0] m;
        if (ex > 896) return {v[63:62], v[58:29]};
        if (ex >= 874) begin
            m = {1'b1, v[51:0]};
            for (int i = 0; i < 926 - int'(ex); i++) m = m / 2;
            return {v[63], 8'd0, m[22:0]};
        end
        return {v[63], 31'd0};
    endfunction

    task automatic drive(input logic [63:0] v, input logic [31:0] expv, input string tag);
        @(posedge clk);
        dbl_in <= v;
        q_in.push_back(v);
        q_exp.push_back(expv);
        q_tag.push_back(tag);
    endtask

    task automatic drive_ref(input logic [63:0] v, input string tag);
        drive(v, ref_narrow(v), tag);
    endtask

    // Monitor: compare half a cycle after each drive.
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [31:0] e;
            logic [63:0] i;
            string t;
            e = q_exp.pop_front();
            i = q_in.pop_front();
            t = q_tag.pop_front();
            n_run++;
            if (sgl_out !== e) begin
                n_fail++;
                $display("FAIL %s in=%h actual=%h expected=%h", t, i, sgl_out, e);
            end
        end
    end

    initial begin
        drive(64'h0, 32'h0, "R5 reset-state zero");
        repeat (2) @(posedge clk);
        rst <= 1'b0;
        drive(64'h3FF0000000000000, 32'h3F800000, "R1 one");
        drive(64'hC004000000000000, 32'hC0200000, "R1 minus 2.5");
        drive(64'h3FF000001FFFFFFF, 32'h3F800000, "R6 normal truncation");
        drive(64'h7FF0000000000000, 32'h7F800000, "R2 +inf");
        drive(64'hFFF0000000000000, 32'hFF800000, "R2 -inf");
        drive(64'h7FF8000000000000, 32'h7FC00000, "R2 qNaN");
        drive(64'h7FF4000020000000, 32'h7FA00001, "R2 sNaN payload");
        drive(64'h3810000000000000, 32'h00800000, "R7 exp 897");
        drive(64'h3800000000000000, 32'h00400000, "R7 exp 896");
        drive(64'hB800000000000000, 32'h80400000, "R3 R4 negative exp 896");
        drive(64'h380000003FFFFFFF, 32'h00400000, "R6 denormal truncation");
        drive(64'h36A0000000000000, 32'h00000001, "R7 exp 874");
        drive(64'hB6A0000000000000, 32'h80000001, "R3 R7 negative exp 874");
        drive(64'h3690000000000000, 32'h00000000, "R7 exp 873");
        drive(64'hB69FFFFFFFFFFFFF, 32'h80000000, "R5 negative exp 873");
        drive(64'h0000000000000000, 32'h00000000, "R5 +zero");
        drive(64'h8000000000000000, 32'h80000000, "R5 -zero");
        drive(64'h37F8000000000000, 32'h00300000, "R4 exp 895 fraction");
        drive(64'h3FF0000000000000, 32'h3F800000, "R8 same-cycle follow");
        for (int k = 0; k < 150; k++) begin
            logic [63:0] v;
            logic [10:0] ex;
            ex = 11'($urandom_range(860, 1160));
            v = {1'($urandom), ex, 20'($urandom), 32'($urandom)};
            drive_ref(v, "R4 R1 random sweep");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule